// File: doc/BRIEF.md
# Event Counter With Compare

This block counts events on a signal that has already been cleaned up by an upstream debounce stage. A zero debounce amount upstream passes raw events straight through. Each rising edge of that signal, seen while the block is enabled, raises a count register by one. A programmable threshold is compared against the count, and a level output reports when the count has reached it.

Software can lower the count by one by pulsing a dedicated decrement strobe. This strobe stands for a write to a special address. The count is always visible on an output bus. The block can therefore run as a plain rate counter that software samples now and then, with the match output left unused.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `evt_counter_cmp`

## Requirements
- R1: After reset the count and the threshold are both zero, so the match output is high.
- R2: While enabled, a rising edge on the event input raises the count by one. A held-high or a falling input adds nothing. An edge is the input being 1 in a cycle where it was 0 in the cycle before.
- R3: While enabled, a decrement strobe with no event in the same cycle lowers a non-zero count by one.
- R4: While enabled, an event and a decrement strobe in the same cycle leave the count unchanged.
- R5: A decrement strobe while the count is zero leaves it at zero.
- R6: The count saturates at all ones (CNT_W bits, default 16) instead of wrapping.
- R7: While the enable is low, the count holds, and events and decrement strobes are ignored. The edge detector keeps tracking the input, so an input that rose while disabled is not counted after the enable returns.
- R8: A threshold write loads the write data one clock edge later, whether or not the block is enabled.
- R9: The match output is high exactly when the count is greater than or equal to the threshold. It changes in the same cycle as the count or the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Counting enable; the count is frozen when low |
| evt_in | input | 1 | Filtered event input |
| dec_pulse | input | 1 | One-cycle decrement strobe |
| cmp_we | input | 1 | Threshold write enable |
| cmp_wdata | input | CNT_W | Threshold write data |
| count_o | output | CNT_W | Current count |
| match_o | output | 1 | High while count >= threshold |

## Verification
A rising edge, a decrement strobe or a threshold write sampled at one clock edge is reflected on `count_o` and `match_o` right after that same edge, with no further register stage. The bench drives every stimulus at a falling edge and samples one nanosecond after the following rising edge. Every expected value in the vector table and in the directed tests is therefore due exactly one edge after it was driven. The saturation and threshold tests reuse this spacing, so a one-cycle slip in any path shows up as a mismatch.

// File: rtl/ec_pkg.sv
package ec_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_UP   = 2'd1,
    ACT_DOWN = 2'd2
  } ec_act_e;

  function automatic ec_act_e ec_pick_action(input logic en,
                                             input logic up,
                                             input logic dn,
                                             input logic at_max,
                                             input logic at_zero);
    ec_act_e a;
    a = ACT_HOLD;
    if (en) begin
      if (up && !dn && !at_max)      a = ACT_UP;
      else if (dn && !up && !at_zero) a = ACT_DOWN;
    end
    return a;
  endfunction

endpackage

// File: rtl/ec_edge_detect.sv
module ec_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic prev_q;

  // The delayed copy tracks the input in every cycle, whatever the enable (R7).
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;

  // R2: a rising edge cannot be reported in two consecutive cycles
  a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/ec_count_core.sv
module ec_count_core
  import ec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  ec_act_e          act;

  assign act = ec_pick_action(en_i, up_i, dn_i,
                              cnt_q == CNT_MAX, cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case (act)
        ACT_UP:   cnt_q <= cnt_q + CNT_W'(1);
        ACT_DOWN: cnt_q <= cnt_q - CNT_W'(1);
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;

  // R3: a lone decrement lowers a non-zero count by one
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && dn_i && !up_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R4: simultaneous event and decrement cancel
  a_r4_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && up_i && dn_i) |=> $stable(cnt_q));

  // R5: no underflow below zero
  a_r5_zero_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && dn_i && !up_i && cnt_q == '0) |=> cnt_q == '0);

  // R6: no wrap past all ones
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && up_i && !dn_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

  // R7: frozen while disabled
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));

endmodule

// File: rtl/ec_compare.sv
module ec_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             match_o
);

  logic [CNT_W-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    thr_q <= '0;
    else if (we_i) thr_q <= wdata_i;
  end

  assign match_o = (cnt_i >= thr_q);

  // R8: threshold write takes effect one edge later
  a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> thr_q == $past(wdata_i));

  // R8: threshold holds without a write
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(thr_q));

endmodule

// File: rtl/evt_counter_cmp.sv
module evt_counter_cmp #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             evt_in,
  input  logic             dec_pulse,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] count_o,
  output logic             match_o
);

  logic             rise;
  logic [CNT_W-1:0] cnt;

  ec_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (evt_in),
    .rise_o (rise)
  );

  ec_count_core #(.CNT_W(CNT_W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (enable),
    .up_i  (rise),
    .dn_i  (dec_pulse),
    .cnt_o (cnt)
  );

  ec_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cmp_we),
    .wdata_i (cmp_wdata),
    .cnt_i   (cnt),
    .match_o (match_o)
  );

  assign count_o = cnt;

  // R2: an enabled rising edge with no decrement raises a non-saturated count
  a_r2_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && evt_in && !$past(evt_in) && !dec_pulse && cnt != {CNT_W{1'b1}})
      |=> count_o == $past(count_o) + CNT_W'(1));

endmodule

// File: tb/evt_counter_cmp_tb.sv
`timescale 1ns/1ps
module evt_counter_cmp_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic         evt_in = 1'b0;
  logic         dec_pulse = 1'b0;
  logic         cmp_we = 1'b0;
  logic [W-1:0] cmp_wdata = '0;
  logic [W-1:0] count_o;
  logic         match_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_counter_cmp #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .evt_in(evt_in),
    .dec_pulse(dec_pulse), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .count_o(count_o), .match_o(match_o)
  );

  // Entry: {req[3:0], en, evt, dec, expected_count[7:0]}
  localparam int NV = 14;
  localparam logic [14:0] VEC [NV] = '{
    {4'd2, 1'b1, 1'b1, 1'b0, 8'd1},  // R2 rising edge counts
    {4'd2, 1'b1, 1'b1, 1'b0, 8'd1},  // R2 held high adds nothing
    {4'd2, 1'b1, 1'b0, 1'b0, 8'd1},  // R2 falling adds nothing
    {4'd2, 1'b1, 1'b1, 1'b0, 8'd2},  // R2 second edge
    {4'd3, 1'b1, 1'b0, 1'b1, 8'd1},  // R3 decrement
    {4'd4, 1'b1, 1'b1, 1'b1, 8'd1},  // R4 cancel
    {4'd3, 1'b1, 1'b0, 1'b1, 8'd0},  // R3 decrement to zero
    {4'd5, 1'b1, 1'b0, 1'b1, 8'd0},  // R5 floor at zero
    {4'd7, 1'b0, 1'b1, 1'b0, 8'd0},  // R7 edge ignored when disabled
    {4'd7, 1'b1, 1'b1, 1'b0, 8'd0},  // R7 no late count of that edge
    {4'd2, 1'b1, 1'b0, 1'b0, 8'd0},
    {4'd2, 1'b1, 1'b1, 1'b0, 8'd1},  // R2 edge after re-enable
    {4'd7, 1'b0, 1'b0, 1'b1, 8'd1},  // R7 decrement ignored when disabled
    {4'd7, 1'b1, 1'b0, 1'b0, 8'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic ev, input logic dn);
    @(negedge clk);
    enable = en; evt_in = ev; dec_pulse = dn;
    @(posedge clk);
    #1;
  endtask

  task automatic write_thr(input logic [W-1:0] v);
    @(negedge clk);
    cmp_we = 1'b1; cmp_wdata = v;
    @(posedge clk);
    #1;
    cmp_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 count", count_o, 0);
    check("R1 match", match_o, 1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][10], VEC[i][9], VEC[i][8]);
      check($sformatf("R%0d vec%0d", VEC[i][14:11], i), count_o, VEC[i][7:0]);
    end
    step(1'b1, 1'b0, 1'b0);

    // R8/R9: threshold 3 above count 1 drops match
    write_thr(8'd3);
    check("R8 match after write", match_o, 0);
    step(1'b1, 1'b1, 1'b0);
    check("R9 count 2 below 3", match_o, 0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    check("R9 count 3 reaches 3", match_o, 1);
    check("R9 count value", count_o, 3);

    // R8: write while disabled
    @(negedge clk); enable = 1'b0; evt_in = 1'b0;
    write_thr(8'd4);
    check("R8 write while disabled", match_o, 0);
    write_thr(8'd2);
    check("R9 count above threshold", match_o, 1);

    // R6: saturation
    write_thr(8'd255);
    for (int k = 0; k < 300; k++) begin
      step(1'b1, 1'b1, 1'b0);
      step(1'b1, 1'b0, 1'b0);
    end
    check("R6 saturated count", count_o, 255);
    check("R9 match at max", match_o, 1);
    step(1'b1, 1'b0, 1'b1);
    check("R6 decrement from max", count_o, 254);
    check("R9 match below max", match_o, 0);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rst_n = 1'b1; #1;
    check("R1 count after reset", count_o, 0);
    check("R1 match after reset", match_o, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule